// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Four-Word Lines

This block is a direct-mapped cache placed between a processor request port and a plain main-memory port. Each byte address is divided, from the least significant end, into a byte field within a word, a field choosing one of four words in a line, a line index, and a tag that fills the remaining upper bits. Every line stores a valid flag, a tag and four 32-bit words.

A read whose line is valid and whose stored tag equals the address tag is answered in the same cycle from the word picked by the word field. Any other read stalls the processor. The cache then fetches all four words of the line from memory one after another, installs them with the new tag, and answers the held request on the first cycle the stall is low.

Writes go straight through to memory and never allocate a line. If the written word is already cached, it is also updated in place. The processor holds its request, address and write data steady while the stall is high. Memory answers each request with a one-cycle acknowledge, and read data is valid in that same cycle.

Top module: `line_cache`

## Requirements
- R1: Address bits [1:0] are the byte offset and are ignored by reads, bits [3:2] pick the word within the line, the next INDEX_W bits are the line index, and all bits above them form the tag.
- R2: After reset every line is invalid, so the first read of any line misses. While cpuReq is low, cpuStall is low.
- R3: A read that finds its line valid with an equal tag raises cpuHit, returns the addressed word on cpuRdata in the same cycle, keeps cpuStall low and makes no memory request.
- R4: A read miss raises cpuStall in the request cycle and holds it until the line is installed. The read then completes with the correct word on the first cycle that cpuStall is low.
- R5: A refill makes exactly four memory reads (memWe low). Their addresses are the line base, base+4, base+8 and base+12, in that order, and each request holds its address until memAck.
- R6: A miss on a valid line with a different tag replaces that line, so a later read of the evicted address misses again.
- R7: Every write issues exactly one memory write of cpuWdata to the word-aligned address (bits [1:0] zero). It makes no memory reads and holds cpuStall high until memAck.
- R8: A write whose line hits also updates that one cached word. Later reads of it hit and return the new value, and the other words of the line are unchanged.
- R9: A write miss does not allocate, so a later read of that address misses and refills with the written value.
- R10: The memory port issues no request while cpuReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held while stalled |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Byte address of the access |
| cpuWdata | input | WORD_W | Write data |
| cpuRdata | output | WORD_W | Read data, valid when a read completes |
| cpuHit | output | 1 | Lookup result for the current address |
| cpuStall | output | 1 | Processor must hold its request |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | Memory write strobe qualifier |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | WORD_W | Memory write data |
| memRdata | input | WORD_W | Memory read data, valid with memAck |
| memAck | input | 1 | One-cycle completion of a memory request |

## Verification
The bench builds the cache with INDEX_W of 4, giving sixteen lines and a 24-bit tag, and a memory model that answers after two wait cycles. With so few lines, addresses 256 bytes apart share an index. That makes it cheap to force replacement, to fill every line and re-read all of them, and to use an address near the top of the space to exercise every tag bit. The refill width stays at four words so that the address stepping and the word select match the real configuration.

// File: rtl/line_cache_pkg.sv
package line_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } cacheState_t;

  typedef struct packed {
    logic fillWrite;    // store memRdata into the word at the refill counter
    logic tagWrite;     // install tag and set valid for the current index
    logic hitWrite;     // overwrite the addressed word with cpuWdata
    logic cntClear;     // restart the refill word counter
    logic useFillAddr;  // memory address comes from the refill counter
  } cacheCtl_t;

endpackage

// File: rtl/line_cache_datapath.sv
module line_cache_datapath
  import line_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int INDEX_W    = 12,
  parameter int WORDS_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cacheCtl_t         ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              lookupHit,
  output logic              fillLast,
  output logic [WORD_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);

  localparam int BYTE_W   = $clog2(WORD_W / 8);
  localparam int LINE_LSB = BYTE_W + WORDS_LOG2;
  localparam int TAG_W    = ADDR_W - LINE_LSB - INDEX_W;
  localparam int LINES    = 1 << INDEX_W;
  localparam int WORDS    = 1 << WORDS_LOG2;

  logic [TAG_W-1:0]      addrTag;
  logic [INDEX_W-1:0]    addrIdx;
  logic [WORDS_LOG2-1:0] addrWord;
  logic [WORDS_LOG2-1:0] fillCnt;

  logic [LINES-1:0]  validQ;
  logic [TAG_W-1:0]  tagMem [LINES];
  logic [WORD_W-1:0] bankOut [WORDS];

  assign addrTag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign addrIdx  = cpuAddr[LINE_LSB +: INDEX_W];
  assign addrWord = cpuAddr[BYTE_W +: WORDS_LOG2];

  // valid flags reset to zero; tags are only meaningful under a set flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (ctl.tagWrite) begin
      validQ[addrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.tagWrite) begin
      tagMem[addrIdx] <= addrTag;
    end
  end

  assign lookupHit = validQ[addrIdx] && (tagMem[addrIdx] == addrTag);

  // one storage bank per word position of the line
  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] bank [LINES];
    logic              fillHere;
    logic              hitHere;

    assign fillHere = ctl.fillWrite && (fillCnt == WORDS_LOG2'(w));
    assign hitHere  = ctl.hitWrite && (addrWord == WORDS_LOG2'(w));

    always_ff @(posedge clk) begin
      if (fillHere) begin
        bank[addrIdx] <= memRdata;
      end else if (hitHere) begin
        bank[addrIdx] <= cpuWdata;
      end
    end

    assign bankOut[w] = bank[addrIdx];
  end

  assign rdData = bankOut[addrWord];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (ctl.cntClear) begin
      fillCnt <= '0;
    end else if (ctl.fillWrite) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign fillLast = (fillCnt == WORDS_LOG2'(WORDS - 1));

  always_comb begin
    if (ctl.useFillAddr) begin
      memAddr = {cpuAddr[ADDR_W-1:LINE_LSB], fillCnt, {BYTE_W{1'b0}}};
    end else begin
      memAddr = {cpuAddr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    end
  end

  assign memWdata = cpuWdata;

endmodule

// File: rtl/line_cache_control.sv
module line_cache_control
  import line_cache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      lookupHit,
  input  logic      fillLast,
  input  logic      memAck,
  output cacheCtl_t ctl,
  output logic      cpuStall,
  output logic      memReq,
  output logic      memWe
);

  cacheState_t stateQ;
  cacheState_t stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD   = stateQ;
    ctl      = '0;
    cpuStall = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        ctl.cntClear = 1'b1;
        if (cpuReq && cpuWe) begin
          cpuStall = 1'b1;
          stateD   = ST_WRITE;
        end else if (cpuReq && !lookupHit) begin
          cpuStall = 1'b1;
          stateD   = ST_FILL;
        end
      end
      ST_FILL: begin
        cpuStall        = 1'b1;
        memReq          = 1'b1;
        ctl.useFillAddr = 1'b1;
        if (memAck) begin
          ctl.fillWrite = 1'b1;
          if (fillLast) begin
            ctl.tagWrite = 1'b1;
            stateD       = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        cpuStall = !memAck;
        if (memAck) begin
          ctl.hitWrite = lookupHit;
          stateD       = ST_IDLE;
        end
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/line_cache.sv
module line_cache
  import line_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int INDEX_W    = 12,
  parameter int WORDS_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  output logic [WORD_W-1:0] cpuRdata,
  output logic              cpuHit,
  output logic              cpuStall,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck
);

  cacheCtl_t ctl;
  logic      lookupHit;
  logic      fillLast;

  line_cache_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cpuWe     (cpuWe),
    .lookupHit (lookupHit),
    .fillLast  (fillLast),
    .memAck    (memAck),
    .ctl       (ctl),
    .cpuStall  (cpuStall),
    .memReq    (memReq),
    .memWe     (memWe)
  );

  line_cache_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .INDEX_W    (INDEX_W),
    .WORDS_LOG2 (WORDS_LOG2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .memRdata  (memRdata),
    .lookupHit (lookupHit),
    .fillLast  (fillLast),
    .rdData    (cpuRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

  assign cpuHit = lookupHit;

endmodule

// File: rtl/line_cache_checker.sv
module line_cache_checker #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int INDEX_W    = 12,
  parameter int WORDS_LOG2 = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuHit,
  input logic              cpuStall,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);

  localparam int BYTE_W   = $clog2(WORD_W / 8);
  localparam int LINE_LSB = BYTE_W + WORDS_LOG2;

  // R4: a read that misses must stall
  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuWe && !cpuHit |-> cpuStall);

  // R3: a read hit completes at once with no memory traffic
  a_r3_hit_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuWe && cpuHit |-> !cpuStall && !memReq);

  // R5: a memory request keeps its address and direction until acknowledged
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R5: refill reads stay inside the missing line and are word aligned
  a_r5_fill_in_line: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> (memAddr[ADDR_W-1:LINE_LSB] == cpuAddr[ADDR_W-1:LINE_LSB])
                         && (memAddr[BYTE_W-1:0] == '0));

  // R7: a write only completes together with its memory write
  a_r7_write_through: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && !cpuStall |-> memReq && memWe && memAck
                                     && (memAddr[ADDR_W-1:BYTE_W] == cpuAddr[ADDR_W-1:BYTE_W]));

  // R7: writes cause no memory reads
  a_r7_no_read_on_write: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe |-> !(memReq && !memWe));

  // R10: memory stays idle without a processor request
  a_r10_idle_mem: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |-> !memReq);

  // R2: no stall without a request
  a_r2_no_stall_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |-> !cpuStall);

endmodule

bind line_cache line_cache_checker #(
  .ADDR_W     (ADDR_W),
  .WORD_W     (WORD_W),
  .INDEX_W    (INDEX_W),
  .WORDS_LOG2 (WORDS_LOG2)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuAddr  (cpuAddr),
  .cpuHit   (cpuHit),
  .cpuStall (cpuStall),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memAck   (memAck)
);

// File: tb/tb_line_cache.sv
module tb_line_cache;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int INDEX_W    = 4;
  localparam int WORDS_LOG2 = 2;
  localparam int LINES      = 1 << INDEX_W;
  localparam int LINE_LSB   = 2 + WORDS_LOG2;
  localparam int MEM_WAIT   = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReq = 1'b0;
  logic              cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [WORD_W-1:0] cpuWdata = '0;
  logic [WORD_W-1:0] cpuRdata;
  logic              cpuHit;
  logic              cpuStall;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memWdata;
  logic [WORD_W-1:0] memRdata = '0;
  logic              memAck = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_cache #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .INDEX_W    (INDEX_W),
    .WORDS_LOG2 (WORDS_LOG2)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .cpuRdata (cpuRdata),
    .cpuHit   (cpuHit),
    .cpuStall (cpuStall),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .memAck   (memAck)
  );

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] initWord(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
  endfunction

  // ---------------- main memory model ----------------
  logic [31:0] extMem [logic [31:0]];
  int          waitCnt = 0;
  int          readCount = 0;
  int          writeCount = 0;
  int          fillPos = 0;
  logic [31:0] lastRdAddr = '0;
  logic [31:0] lastWrAddr = '0;
  logic [31:0] lastWrData = '0;

  always @(negedge clk) begin
    if (memAck) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt == MEM_WAIT) begin
        memAck <= 1'b1;
        if (memWe) begin
          extMem[memAddr] = memWdata;
          writeCount++;
          lastWrAddr = memAddr;
          lastWrData = memWdata;
        end else begin
          memRdata <= extMem.exists(memAddr) ? extMem[memAddr] : initWord(memAddr);
          if (fillPos == 0)
            check(memAddr[3:0] == 4'h0, "R5", "refill first address", memAddr, {memAddr[31:4], 4'h0});
          else
            check(memAddr == lastRdAddr + 32'd4, "R5", "refill address step", memAddr, lastRdAddr + 32'd4);
          lastRdAddr = memAddr;
          fillPos    = (fillPos + 1) % 4;
          readCount++;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] refMem [logic [31:0]];
  bit          refValid [LINES];
  logic [ADDR_W-LINE_LSB-INDEX_W-1:0] refTag [LINES];

  typedef struct {
    bit          isRead;
    logic [31:0] data;
    logic [31:0] addr;
  } expItem_t;

  expItem_t expQ[$];

  // monitor: pops one expected item for every completed access
  always begin
    @(negedge clk);
    #3;
    if (rstN && cpuReq && !cpuStall) begin
      if (expQ.size() == 0) begin
        check(0, "R4", "unexpected completion", cpuAddr, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.isRead)
          check(cpuRdata == it.data, "R3", $sformatf("read data @%h", it.addr), cpuRdata, it.data);
      end
    end
  end

  task automatic access(bit we, logic [31:0] addr, logic [31:0] wdata, string req);
    int idx;
    logic [31:0] wa;
    bit expHit;
    int rdBefore;
    int wrBefore;
    expItem_t it;
    idx    = int'(addr[LINE_LSB +: INDEX_W]);
    wa     = {addr[31:2], 2'b00};
    expHit = refValid[idx] && (refTag[idx] == addr[31:LINE_LSB+INDEX_W]);
    rdBefore = readCount;
    wrBefore = writeCount;
    @(negedge clk);
    #1;
    cpuReq   = 1'b1;
    cpuWe    = we;
    cpuAddr  = addr;
    cpuWdata = wdata;
    it.isRead = !we;
    it.addr   = addr;
    it.data   = we ? wdata : (refMem.exists(wa) ? refMem[wa] : initWord(wa));
    expQ.push_back(it);
    #1;
    check(cpuHit == expHit, req, $sformatf("hit flag @%h", addr), 32'(cpuHit), 32'(expHit));
    check(cpuStall == (we || !expHit), we ? "R7" : "R4",
          $sformatf("first-cycle stall @%h", addr), 32'(cpuStall), 32'(we || !expHit));
    while (cpuStall) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    cpuReq = 1'b0;
    cpuWe  = 1'b0;
    if (we) begin
      check(readCount == rdBefore, "R7", "no reads on write", 32'(readCount - rdBefore), 32'd0);
      check(writeCount == wrBefore + 1, "R7", "one memory write", 32'(writeCount - wrBefore), 32'd1);
      check(lastWrAddr == wa && lastWrData == wdata, "R7", "write address", lastWrAddr, wa);
      refMem[wa] = wdata;
    end else begin
      check(readCount == rdBefore + (expHit ? 0 : 4), expHit ? "R3" : "R5", "read count",
            32'(readCount - rdBefore), expHit ? 32'd0 : 32'd4);
      if (!expHit) begin
        refValid[idx] = 1'b1;
        refTag[idx]   = addr[31:LINE_LSB+INDEX_W];
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      refValid[i] = 1'b0;
      refTag[i]   = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R2: idle after reset
    check(cpuStall == 1'b0, "R2", "stall after reset", 32'(cpuStall), 32'd0);
    check(memReq == 1'b0, "R10", "memory idle after reset", 32'(memReq), 32'd0);

    // R2 R4 R5: compulsory miss then hits on every word of the line (R1 word select)
    access(0, 32'h0000_0100, '0, "R2");
    access(0, 32'h0000_0104, '0, "R1");
    access(0, 32'h0000_0108, '0, "R1");
    access(0, 32'h0000_010C, '0, "R1");
    // R1: byte offset bits ignored
    access(0, 32'h0000_010B, '0, "R1");
    access(0, 32'h0000_0101, '0, "R3");

    // R6: same index, different tag evicts
    access(0, 32'h0000_0200, '0, "R6");
    access(0, 32'h0000_0104, '0, "R6");

    // R8: write hit updates one word only
    access(1, 32'h0000_0106, 32'hCAFE_0001, "R8");
    access(0, 32'h0000_0104, '0, "R8");
    access(0, 32'h0000_0100, '0, "R8");
    access(0, 32'h0000_0108, '0, "R8");

    // R9: write miss does not allocate
    access(1, 32'h0000_0308, 32'hBEEF_0002, "R9");
    access(0, 32'h0000_0308, '0, "R9");
    access(0, 32'h0000_0300, '0, "R9");

    // fill all lines, then re-read them all (R3 R4)
    for (int i = 0; i < LINES; i++)
      access(0, 32'h0000_1000 + 32'(i * 16) + 32'(4 * (i % 4)), '0, "R4");
    for (int i = 0; i < LINES; i++)
      access(0, 32'h0000_1000 + 32'(i * 16) + 32'(4 * ((i + 1) % 4)), '0, "R3");

    // full tag width (R1 R6)
    access(0, 32'hFFFF_FFF4, '0, "R6");
    access(0, 32'hFFFF_FFF0, '0, "R1");
    access(0, 32'h0000_10F0, '0, "R6");
    access(1, 32'h0000_10FC, 32'h1234_5678, "R8");
    access(0, 32'h0000_10FC, '0, "R8");

    repeat (4) @(posedge clk);
    #1;
    check(memReq == 1'b0 && cpuStall == 1'b0, "R10", "idle at end", 32'(memReq), 32'd0);
    check(expQ.size() == 0, "R4", "all accesses completed", 32'(expQ.size()), 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule